// File: doc/BRIEF.md
# Protected Frame Encoder

This block builds one protected line frame per bunch-crossing clock on the transmit side of a link. It takes a 64-bit payload word, which a scrambler upstream has normally already whitened. It also takes a flag that marks the word as user data or as filler. From these it forms an 88-bit parallel frame with a valid strobe for the serializer that follows.

The payload is protected by two interleaved shortened Reed-Solomon codes over GF(16). Together they add 16 parity bits, so the payload and parity form an 80-bit codeword. An 8-bit header in front of the codeword tells the receiver whether the frame carries data or idle filler. The two header values are bit-wise complements, so the receiver can still tell them apart after several bit errors.

A bypass control removes the parity protection. A filler indication replaces the payload with a fixed idle pattern. In every mode the frame appears exactly two clocks after its strobe, so the block adds a constant latency to a synchronous trigger or data path. It carries 64 payload bits out of every 88 line bits.

Top module: `prot_frame_enc`

## Requirements
- R1: The frame layout is: header in bits [87:80], payload in bits [79:16], parity in bits [15:0].
- R2: A strobe with `bx_is_data`=1 yields header 8'h5A and a payload equal to `bx_word`.
- R3: A strobe with `bx_is_data`=0 yields header 8'hA5 and the fixed idle payload 64'hC3C3_C3C3_3C3C_3C3C. In this case `bx_word` is ignored.
- R4: With the bypass off, the parity follows the rules below, and every syndrome of the frame's codeword at alpha^0 and alpha^1 is zero.
  - The symbols are 4-bit GF(16) elements with the field polynomial x^4+x+1, where alpha = 4'h2.
  - Codeword nibble k is bits [4k+3:4k] of frame[79:0].
  - The even-numbered nibbles form code A. Its coefficient of x^j is nibble 2j.
  - The odd-numbered nibbles form code B. Its coefficient of x^j is nibble 2j+1.
  - Each code is RS(10,8) with generator roots alpha^0 and alpha^1.
- R5: A strobe with `rs_bypass`=1 yields parity bits all zero. The header and payload are the same as with the bypass off.
- R6: `frame_valid` is high in exactly the second cycle after a cycle with `bx_strobe` high, and in no other cycle.
- R7: When `frame_valid` is low, `frame_out` holds the last frame.
- R8: During reset, `frame_valid` is 0 and `frame_out` is all zero.
- R9: Strobes in consecutive cycles yield a distinct, correct frame in each consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bx_strobe | input | 1 | A frame is requested this cycle |
| bx_is_data | input | 1 | 1: payload is user data; 0: send an idle frame |
| bx_word | input | 64 | Payload word, normally scrambled |
| rs_bypass | input | 1 | 1: skip the parity stage; parity field is zero |
| frame_valid | output | 1 | `frame_out` carries a new frame this cycle |
| frame_out | output | 88 | Header, payload and parity |

## Verification
Each cycle, a reference model in the bench predicts the valid strobe and all 88 frame bits, and the bench compares them with the outputs. The model derives the parity by solving the two syndrome equations of each code, not by dividing by the generator.

A wrong internal state has different effects depending on where it sits:
- A stale or corrupted pipeline register changes the frame in the same cycle the frame is due, two clocks after the strobe.
- A wrong field constant or a wrong lane mapping corrupts the parity nibbles of the very first non-bypassed frame.
- A lost or duplicated valid bit shows up as a strobe mismatch at that same two-cycle offset.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

   localparam int SYM_W = 4;
   localparam logic [SYM_W:0] GF_POLY = 5'b10011;
   localparam logic [SYM_W-1:0] GF_ALPHA = 4'h2;
   localparam int GF_ORDER = (1 << SYM_W) - 1;

   typedef logic [SYM_W-1:0] sym_t;

   typedef enum logic {
      KIND_IDLE = 1'b0,
      KIND_DATA = 1'b1
   } frame_kind_e;

   function automatic sym_t gf_mul(input sym_t a, input sym_t b);
      sym_t acc;
      sym_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < SYM_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[SYM_W-1] ? (sym_t'(sh << 1) ^ GF_POLY[SYM_W-1:0]) : sym_t'(sh << 1);
      end
      return acc;
   endfunction

endpackage

// File: rtl/pfe_rs_lane.sv
module pfe_rs_lane
   import pfe_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANES  = 2,
   parameter int LANE   = 0
) (
   input  logic [DATA_W-1:0] word_i,
   output sym_t              rem_hi_o,
   output sym_t              rem_lo_o
);

   localparam int SPL = DATA_W / (SYM_W * LANES);
   localparam sym_t G1 = sym_t'(1) ^ GF_ALPHA;
   localparam sym_t G0 = GF_ALPHA;

   sym_t hi_q [SPL+1];
   sym_t lo_q [SPL+1];

   assign hi_q[0] = '0;
   assign lo_q[0] = '0;

   generate
      for (genvar t = 0; t < SPL; t++) begin : g_step
         localparam int K   = SPL - 1 - t;
         localparam int NIB = K * LANES + LANE;
         sym_t sym;
         sym_t fb;
         assign sym = word_i[NIB*SYM_W +: SYM_W];
         assign fb  = sym ^ hi_q[t];
         assign hi_q[t+1] = lo_q[t] ^ gf_mul(fb, G1);
         assign lo_q[t+1] = gf_mul(fb, G0);
      end
   endgenerate

   assign rem_hi_o = hi_q[SPL];
   assign rem_lo_o = lo_q[SPL];

endmodule

// File: rtl/pfe_parity_gen.sv
module pfe_parity_gen
   import pfe_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int LANES     = 2,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic [DATA_W-1:0]          word_i,
   input  logic                       bypass_i,
   output logic [2*LANES*SYM_W-1:0]   par_o
);

   localparam int PAR_W = 2 * LANES * SYM_W;

   generate
      if (PARITY_EN) begin : g_rs
         logic [PAR_W-1:0] raw;
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            sym_t r_hi;
            sym_t r_lo;
            pfe_rs_lane #(
               .DATA_W (DATA_W),
               .LANES  (LANES),
               .LANE   (l)
            ) u_lane (
               .word_i   (word_i),
               .rem_hi_o (r_hi),
               .rem_lo_o (r_lo)
            );
            assign raw[l*SYM_W +: SYM_W]           = r_lo;
            assign raw[(LANES+l)*SYM_W +: SYM_W]   = r_hi;
         end
         assign par_o = bypass_i ? '0 : raw;
      end else begin : g_none
         assign par_o = {PAR_W{1'b0}} & {PAR_W{bypass_i}} & {PAR_W{|word_i}};
      end
   endgenerate

endmodule

// File: rtl/pfe_front.sv
module pfe_front
   import pfe_pkg::*;
#(
   parameter int                DATA_W    = 64,
   parameter int                HDR_W     = 8,
   parameter logic [HDR_W-1:0]  HDR_DATA  = 8'h5A,
   parameter logic [HDR_W-1:0]  HDR_IDLE  = 8'hA5,
   parameter logic [DATA_W-1:0] IDLE_WORD = 64'hC3C3_C3C3_3C3C_3C3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic              is_data_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              bypass_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] word_o,
   output logic [HDR_W-1:0]  hdr_o,
   output logic              bypass_o
);

   frame_kind_e      kind;
   logic [DATA_W-1:0] sel_word;
   logic [HDR_W-1:0]  sel_hdr;

   always_comb begin
      kind = is_data_i ? KIND_DATA : KIND_IDLE;
      unique case (kind)
         KIND_DATA: begin
            sel_word = word_i;
            sel_hdr  = HDR_DATA;
         end
         default: begin
            sel_word = IDLE_WORD;
            sel_hdr  = HDR_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o    <= 1'b0;
         word_o   <= '0;
         hdr_o    <= '0;
         bypass_o <= 1'b0;
      end else begin
         vld_o <= strobe_i;
         if (strobe_i) begin
            word_o   <= sel_word;
            hdr_o    <= sel_hdr;
            bypass_o <= bypass_i;
         end
      end
   end

endmodule

// File: rtl/prot_frame_enc.sv
module prot_frame_enc
   import pfe_pkg::*;
#(
   parameter int                DATA_W    = 64,
   parameter int                LANES     = 2,
   parameter int                HDR_W     = 8,
   parameter logic [HDR_W-1:0]  HDR_DATA  = 8'h5A,
   parameter logic [HDR_W-1:0]  HDR_IDLE  = 8'hA5,
   parameter logic [DATA_W-1:0] IDLE_WORD = 64'hC3C3_C3C3_3C3C_3C3C,
   parameter bit                PARITY_EN = 1'b1,
   localparam int PAR_W   = 2 * LANES * SYM_W,
   localparam int FRAME_W = HDR_W + DATA_W + PAR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bx_strobe,
   input  logic               bx_is_data,
   input  logic [DATA_W-1:0]  bx_word,
   input  logic               rs_bypass,
   output logic               frame_valid,
   output logic [FRAME_W-1:0] frame_out
);

   localparam int SPL = DATA_W / (SYM_W * LANES);

   generate
      if (DATA_W % (SYM_W * LANES) != 0) begin : g_bad_width
         $error("payload width must split evenly into symbols per lane");
      end
      if (SPL + 2 > GF_ORDER) begin : g_bad_len
         $error("codeword per lane exceeds the field length");
      end
      if (HDR_DATA == HDR_IDLE) begin : g_bad_hdr
         $error("data and idle headers must differ");
      end
   endgenerate

   logic              s1_vld;
   logic [DATA_W-1:0] s1_word;
   logic [HDR_W-1:0]  s1_hdr;
   logic              s1_byp;
   logic [PAR_W-1:0]  s1_par;

   pfe_front #(
      .DATA_W    (DATA_W),
      .HDR_W     (HDR_W),
      .HDR_DATA  (HDR_DATA),
      .HDR_IDLE  (HDR_IDLE),
      .IDLE_WORD (IDLE_WORD)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_i  (bx_strobe),
      .is_data_i (bx_is_data),
      .word_i    (bx_word),
      .bypass_i  (rs_bypass),
      .vld_o     (s1_vld),
      .word_o    (s1_word),
      .hdr_o     (s1_hdr),
      .bypass_o  (s1_byp)
   );

   pfe_parity_gen #(
      .DATA_W    (DATA_W),
      .LANES     (LANES),
      .PARITY_EN (PARITY_EN)
   ) u_par (
      .word_i   (s1_word),
      .bypass_i (s1_byp),
      .par_o    (s1_par)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         frame_out   <= '0;
      end else begin
         frame_valid <= s1_vld;
         if (s1_vld) frame_out <= {s1_hdr, s1_word, s1_par};
      end
   end

endmodule

// File: rtl/pfe_chk.sv
module pfe_chk
   import pfe_pkg::*;
#(
   parameter int                DATA_W    = 64,
   parameter int                LANES     = 2,
   parameter int                HDR_W     = 8,
   parameter logic [HDR_W-1:0]  HDR_DATA  = 8'h5A,
   parameter logic [HDR_W-1:0]  HDR_IDLE  = 8'hA5,
   parameter logic [DATA_W-1:0] IDLE_WORD = 64'hC3C3_C3C3_3C3C_3C3C,
   localparam int PAR_W   = 2 * LANES * SYM_W,
   localparam int CW_W    = DATA_W + PAR_W,
   localparam int FRAME_W = HDR_W + CW_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bx_strobe,
   input logic               bx_is_data,
   input logic [DATA_W-1:0]  bx_word,
   input logic               rs_bypass,
   input logic               frame_valid,
   input logic [FRAME_W-1:0] frame_out
);

   localparam int NPL = CW_W / (SYM_W * LANES);

   logic synd_ok;

   always_comb begin
      synd_ok = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         for (int r = 0; r < 2; r++) begin
            sym_t s;
            sym_t apow;
            sym_t step;
            s    = '0;
            apow = sym_t'(1);
            step = (r == 0) ? sym_t'(1) : GF_ALPHA;
            for (int j = 0; j < NPL; j++) begin
               s    = s ^ gf_mul(frame_out[(j*LANES+l)*SYM_W +: SYM_W], apow);
               apow = gf_mul(apow, step);
            end
            if (s != '0) synd_ok = 1'b0;
         end
      end
   end

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bx_strobe |=> ##1 frame_valid);

   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_strobe |=> ##1 !frame_valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(frame_out));

   p_data_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && bx_is_data) |=> ##1
         (frame_out[FRAME_W-1 -: HDR_W] == HDR_DATA &&
          frame_out[FRAME_W-HDR_W-1 -: DATA_W] == $past(bx_word, 2)));

   p_idle_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && !bx_is_data) |=> ##1
         (frame_out[FRAME_W-1 -: HDR_W] == HDR_IDLE &&
          frame_out[FRAME_W-HDR_W-1 -: DATA_W] == IDLE_WORD));

   p_bypass_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && rs_bypass) |=> ##1 (frame_out[PAR_W-1:0] == '0));

   p_syndrome_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && !rs_bypass) |=> ##1 synd_ok);

endmodule

bind prot_frame_enc pfe_chk #(
   .DATA_W    (DATA_W),
   .LANES     (LANES),
   .HDR_W     (HDR_W),
   .HDR_DATA  (HDR_DATA),
   .HDR_IDLE  (HDR_IDLE),
   .IDLE_WORD (IDLE_WORD)
) u_pfe_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bx_strobe   (bx_strobe),
   .bx_is_data  (bx_is_data),
   .bx_word     (bx_word),
   .rs_bypass   (rs_bypass),
   .frame_valid (frame_valid),
   .frame_out   (frame_out)
);

// File: tb/prot_frame_enc_tb_top.sv
module prot_frame_enc_tb_top;

   localparam logic [63:0] IDLE_W = 64'hC3C3_C3C3_3C3C_3C3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bx_strobe = 1'b0;
   logic        bx_is_data = 1'b0;
   logic [63:0] bx_word = '0;
   logic        rs_bypass = 1'b0;
   logic        frame_valid;
   logic [87:0] frame_out;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   string vreq  = "R6";

   always #2 clk = ~clk;

   prot_frame_enc dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bx_strobe   (bx_strobe),
      .bx_is_data  (bx_is_data),
      .bx_word     (bx_word),
      .rs_bypass   (rs_bypass),
      .frame_valid (frame_valid),
      .frame_out   (frame_out)
   );

   // behavioural field arithmetic, integer based
   function automatic int fmul(int a, int b);
      int acc = 0;
      for (int i = 0; i < 4; i++) begin
         if ((b >> i) & 1) acc = acc ^ a;
         a = a << 1;
         if (a & 16) a = a ^ 19;
      end
      return acc;
   endfunction

   function automatic int fpow(int j);
      int v = 1;
      for (int i = 0; i < j; i++) v = fmul(v, 2);
      return v;
   endfunction

   function automatic int finv(int a);
      for (int x = 1; x < 16; x++) if (fmul(a, x) == 1) return x;
      return 0;
   endfunction

   // solve S0 = 0 and S1 = 0 for the two parity symbols of each code
   function automatic logic [15:0] ref_parity(logic [63:0] w);
      logic [15:0] p = '0;
      for (int l = 0; l < 2; l++) begin
         int d0 = 0;
         int d1 = 0;
         int p0, p1;
         for (int k = 0; k < 8; k++) begin
            int s = int'(w[4*(2*k+l) +: 4]);
            d0 = d0 ^ s;
            d1 = d1 ^ fmul(s, fpow(k + 2));
         end
         p1 = fmul(d0 ^ d1, finv(3));
         p0 = d0 ^ p1;
         p[4*l +: 4]     = 4'(p0);
         p[4*(2+l) +: 4] = 4'(p1);
      end
      return p;
   endfunction

   function automatic logic [87:0] ref_frame(logic isd, logic [63:0] w, logic byp);
      logic [63:0] pay = isd ? w : IDLE_W;
      logic [7:0]  hdr = isd ? 8'h5A : 8'hA5;
      logic [15:0] par = byp ? 16'h0 : ref_parity(pay);
      return {hdr, pay, par};
   endfunction

   // reference pipeline
   logic        m1_v = 0, m2_v = 0;
   logic [87:0] m1_f = '0, m2_f = '0;
   logic        m1_d = 0, m2_d = 0, m1_b = 0, m2_b = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m1_v = 0; m2_v = 0; m1_f = '0; m2_f = '0;
         m1_d = 0; m2_d = 0; m1_b = 0; m2_b = 0;
      end else begin
         m2_v = m1_v;
         if (m1_v) begin
            m2_f = m1_f; m2_d = m1_d; m2_b = m1_b;
         end
         m1_v = bx_strobe;
         if (bx_strobe) begin
            m1_f = ref_frame(bx_is_data, bx_word, rs_bypass);
            m1_d = bx_is_data;
            m1_b = rs_bypass;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
      end
   endtask

   task automatic compare();
      if (!rst_n) begin
         chk(frame_valid == 1'b0 && frame_out == '0, "R8",
             {87'b0, frame_valid} ^ frame_out, 88'h0);
      end else begin
         chk(frame_valid == m2_v, vreq, 88'(frame_valid), 88'(m2_v));
         if (m2_v) begin
            chk(frame_out[87:80] == m2_f[87:80], m2_d ? "R2" : "R3",
                88'(frame_out[87:80]), 88'(m2_f[87:80]));
            chk(frame_out[79:16] == m2_f[79:16], m2_d ? "R2" : "R3",
                88'(frame_out[79:16]), 88'(m2_f[79:16]));
            chk(frame_out[15:0] == m2_f[15:0], m2_b ? "R5" : "R4",
                88'(frame_out[15:0]), 88'(m2_f[15:0]));
            chk(frame_out == m2_f, "R1", frame_out, m2_f);
         end else begin
            chk(frame_out == m2_f, "R7", frame_out, m2_f);
         end
      end
   endtask

   task automatic step(input logic stb, input logic isd, input logic [63:0] w, input logic byp);
      @(negedge clk);
      compare();
      bx_strobe  = stb;
      bx_is_data = isd;
      bx_word    = w;
      rs_bypass  = byp;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            finish_run();
         end
      end
   end

   initial begin : stim
      // R8: reset state
      for (int i = 0; i < 4; i++) step(0, 0, rnd64(), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: back-to-back data frames, parity on
      vreq = "R9";
      for (int i = 0; i < 40; i++) step(1, 1, rnd64(), 0);
      // corner payloads: zero, ones, single nibble
      step(1, 1, 64'h0, 0);
      step(1, 1, {64{1'b1}}, 0);
      for (int n = 0; n < 16; n++) step(1, 1, 64'hF << (4 * n), 0);
      vreq = "R6";

      // R7 and R6: sparse strobes, word changes in gaps
      for (int i = 0; i < 60; i++) step(($urandom() % 3) == 0, 1, rnd64(), 0);

      // R3: idle frames with varying ignored words
      for (int i = 0; i < 20; i++) step(1, 0, rnd64(), 0);
      step(1, 0, 64'h0, 1);

      // R5: bypass on data and idle
      for (int i = 0; i < 20; i++) step(1, 1, rnd64(), 1);

      // mixed traffic
      for (int i = 0; i < 400; i++)
         step(($urandom() % 4) != 0, ($urandom() % 3) != 0, rnd64(), ($urandom() % 4) == 0);

      for (int i = 0; i < 4; i++) step(0, 0, 64'h0, 0);

      // reset in mid-stream
      step(1, 1, rnd64(), 0);
      @(negedge clk);
      rst_n = 1'b0;
      bx_strobe = 1'b0;
      for (int i = 0; i < 3; i++) step(0, 0, 64'h0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) step(1, 1, rnd64(), 0);
      for (int i = 0; i < 3; i++) step(0, 0, 64'h0, 0);

      finish_run();
   end

endmodule